// File: doc/BRIEF.md
# Quasi-Bidirectional Port Driver

This block drives a group of general-purpose pins that have no direction register. Each pin holds one bit written by software. A bit at 0 sinks the pin hard. A bit at 1 leaves the pin on a weak pullup. That weak-high state is also the input mode, because any outside driver can overpower it and pull the pin low. The pin levels are brought back in through a two-stage synchroniser, so software can read them safely.

When a bit goes from 0 to 1, the block turns on a strong pullup for a fixed number of cycles, which charges the pin quickly. It then hands the pin over to the weak sustaining pullup. Each pin has three separate enables (sink, boost and hold) for the pad cell outside this block, and exactly one of them is active at any time.

Software writes arrive over a valid/ready port. The port never applies back-pressure: `wr_ready` is always high, and a word is accepted on every clock edge where `wr_valid` is high. When `wr_valid` is low, `wr_data` has no effect. The written bits can be read back on `latch_rd`, separately from the synchronised pin levels on `pin_rd`.

Top module: `qbp_port`

## Requirements
- R1: A synchronous reset (`rst` high) sets every latch bit to 1, clears `pd_en` and `spu_en`, sets `wpu_en` to all ones, and loads the synchroniser with all ones.
- R2: An accepted write with a bit at 0 sets that bit's `pd_en` from the next cycle. The pullups of that pin are off. The state holds until the bit is written with 1 or reset occurs.
- R3: An accepted write of 1 to a bit whose latch holds 0 raises that bit's `spu_en` for exactly PULSE_CYC cycles (default 2), starting the cycle after the write. `wpu_en` is low during those cycles.
- R4: When the boost pulse ends, the pin's `spu_en` drops and its `wpu_en` rises, and the pin stays in the weak-high state.
- R5: Writing 1 to a bit that already holds 1 neither starts nor extends a boost pulse.
- R6: Writing 0 to a bit while its boost pulse runs ends the pulse at once: the next cycle shows `pd_en` high and `spu_en` low.
- R7: For every pin, in every cycle, exactly one of `pd_en`, `spu_en` and `wpu_en` is high.
- R8: `pin_rd` equals `pin_in` as sampled two clock edges earlier.
- R9: `latch_rd` returns the latch contents, whatever the pin levels are.
- R10: `wr_ready` is always 1. While `wr_valid` is low, `wr_data` changes neither the latch nor the enables.
- R11: A reset asserted during a boost pulse ends the pulse. After the reset edge, the pin is weak-high with its latch at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_data | input | WIDTH | Value to load into the latch |
| pin_in | input | WIDTH | Pin levels from the pads |
| pin_rd | output | WIDTH | Synchronised pin levels |
| latch_rd | output | WIDTH | Latch contents |
| pd_en | output | WIDTH | Strong pulldown enable, per pin |
| spu_en | output | WIDTH | Momentary strong pullup enable, per pin |
| wpu_en | output | WIDTH | Weak pullup enable, per pin |

## Verification
Some properties are checked by assertions on every cycle and for every pin:
- exactly one enable is active;
- a write of 0 brings up the sink on the next cycle;
- a 0-to-1 write brings up the boost;
- a write of 1 over a steady 1 never starts a pulse;
- a boost never runs longer than PULSE_CYC;
- the weak hold follows the end of a pulse;
- the synchroniser delays its input by two edges.

Other behaviour only the bench scenarios can show. These are the exact cycles in which mixed-bit words change the enables, a pulse cancelled by a 0 write, a re-write of 1 during a pulse that must not stretch it, writes ignored while `wr_valid` is low, and a reset that arrives in the middle of a pulse.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef enum logic [1:0] {
    DRV_HOLD  = 2'd0,
    DRV_BOOST = 2'd1,
    DRV_SINK  = 2'd2
  } drive_e;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;

  // checker: edges since reset, saturating at 2
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r8_two_stage_delay: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (d_out == $past(d_in, 2)));
endmodule

// File: rtl/qbp_pin_cell.sv
module qbp_pin_cell
  import qbp_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic latch_q,
  output logic pd_en,
  output logic spu_en,
  output logic wpu_en
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] boost_q;
  logic          boost_live;
  drive_e        drv;

  assign boost_live = (boost_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b1;
      boost_q <= '0;
    end else if (wr_en) begin
      latch_q <= wr_bit;
      if (!wr_bit)           boost_q <= '0;
      else if (!latch_q)     boost_q <= LOAD;
      else if (boost_live)   boost_q <= boost_q - 1'b1;
    end else if (boost_live) begin
      boost_q <= boost_q - 1'b1;
    end
  end

  always_comb begin
    if (!latch_q)        drv = DRV_SINK;
    else if (boost_live) drv = DRV_BOOST;
    else                 drv = DRV_HOLD;
  end

  assign pd_en  = (drv == DRV_SINK);
  assign spu_en = (drv == DRV_BOOST);
  assign wpu_en = (drv == DRV_HOLD);

  // checker: length of the current boost run
  logic [CW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (spu_en) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r7_one_enable: assert property (@(posedge clk) disable iff (rst)
    $countones({pd_en, spu_en, wpu_en}) == 1);
  a_r2_sink_after_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bit) |=> (pd_en && !spu_en && !wpu_en));
  a_r3_boost_on_rise: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bit && pd_en) |=> spu_en);
  a_r3_boost_bounded: assert property (@(posedge clk) disable iff (rst)
    spu_en |-> (run_q < (CW+1)'(PULSE_CYC)));
  a_r5_no_pulse_on_steady: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bit && wpu_en) |=> !spu_en);
  a_r4_hold_after_boost: assert property (@(posedge clk) disable iff (rst)
    ($fell(spu_en) && !pd_en) |-> wpu_en);
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_rd,
  output logic [WIDTH-1:0] latch_rd,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] spu_en,
  output logic [WIDTH-1:0] wpu_en
);
  logic wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    qbp_pin_cell #(.PULSE_CYC(PULSE_CYC)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_fire),
      .wr_bit  (wr_data[i]),
      .latch_q (latch_rd[i]),
      .pd_en   (pd_en[i]),
      .spu_en  (spu_en[i]),
      .wpu_en  (wpu_en[i])
    );
  end

  qbp_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pin_in),
    .d_out (pin_rd)
  );

  a_r10_idle_keeps_latch: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(latch_rd));
endmodule

// File: tb/sim_qbp_port.sv
module sim_qbp_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] pin_in = 8'h5A;
  logic [7:0] pin_rd, latch_rd, pd_en, spu_en, wpu_en;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qbp_port #(.WIDTH(8), .PULSE_CYC(2)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pin_in(pin_in), .pin_rd(pin_rd), .latch_rd(latch_rd),
    .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en)
  );

  // {valid, data, exp latch, exp pd, exp spu, exp wpu}; outputs after the edge
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h0F, 8'h0F, 8'hF0, 8'h00, 8'h0F},  // R2 sink upper nibble
    {1'b1, 8'hFF, 8'hFF, 8'h00, 8'hF0, 8'h0F},  // R3 boost cycle 1
    {1'b0, 8'h00, 8'hFF, 8'h00, 8'hF0, 8'h0F},  // R3 cycle 2, R10 data ignored
    {1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},  // R4 hand-over
    {1'b1, 8'hAA, 8'hAA, 8'h55, 8'h00, 8'hAA},
    {1'b1, 8'hFF, 8'hFF, 8'h00, 8'h55, 8'hAA},
    {1'b1, 8'hF5, 8'hF5, 8'h0A, 8'h55, 8'hA0},  // R5 no extension, R2 mixed
    {1'b0, 8'h00, 8'hF5, 8'h0A, 8'h00, 8'hF5},
    {1'b1, 8'hF0, 8'hF0, 8'h0F, 8'h00, 8'hF0},
    {1'b1, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'hF0},
    {1'b1, 8'hF0, 8'hF0, 8'h0F, 8'h00, 8'hF0},  // R6 cancel by zero
    {1'b1, 8'hF0, 8'hF0, 8'h0F, 8'h00, 8'hF0},
    {1'b1, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'hF0},
    {1'b1, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'hF0},  // R5 re-write 1 in pulse
    {1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_onehot(input string tag);
    chk({"R7 ", tag}, (pd_en & spu_en) | (pd_en & wpu_en) | (spu_en & wpu_en), 8'h00);
    chk({"R7 ", tag}, pd_en | spu_en | wpu_en, 8'hFF);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    tick();
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 latch", latch_rd, 8'hFF);
    chk("R1 pd", pd_en, 8'h00);
    chk("R1 spu", spu_en, 8'h00);
    chk("R1 wpu", wpu_en, 8'hFF);
    chk("R1 pin_rd", pin_rd, 8'hFF);
    chk("R10 ready", {7'd0, wr_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      wr_valid = VEC[i][40];
      wr_data  = VEC[i][39:32];
      tick();
      wr_valid = 1'b0;
      chk($sformatf("R9 latch step %0d", i), latch_rd, VEC[i][31:24]);
      chk($sformatf("R2 pd step %0d", i), pd_en, VEC[i][23:16]);
      chk($sformatf("R3 spu step %0d", i), spu_en, VEC[i][15:8]);
      chk($sformatf("R4 wpu step %0d", i), wpu_en, VEC[i][7:0]);
      chk_onehot($sformatf("step %0d", i));
    end

    // R9 latch readback independent of pins, R8 synchroniser delay
    pin_in = 8'h3C;
    tick();
    chk("R8 pin_rd after 1 edge", pin_rd, 8'h5A);
    chk("R9 latch vs pins", latch_rd, 8'hFF);
    tick();
    chk("R8 pin_rd after 2 edges", pin_rd, 8'h3C);

    // R10 idle bus with changing data
    wr_data = 8'h00;
    tick();
    chk("R10 idle latch", latch_rd, 8'hFF);
    chk("R10 idle pd", pd_en, 8'h00);

    // R11 reset in the middle of a pulse
    write(8'h00);
    chk("R2 all sink", pd_en, 8'hFF);
    write(8'hFF);
    chk("R3 all boost", spu_en, 8'hFF);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R11 spu", spu_en, 8'h00);
    chk("R11 wpu", wpu_en, 8'hFF);
    chk("R11 pd", pd_en, 8'h00);
    chk("R11 latch", latch_rd, 8'hFF);
    tick();
    chk("R11 no late pulse", spu_en, 8'h00);

    // R6 single-bit cancel on the first pulse cycle
    write(8'hFE);
    write(8'hFF);
    chk("R6 bit0 boost", spu_en, 8'h01);
    write(8'hFE);
    chk("R6 bit0 sink", pd_en, 8'h01);
    chk("R6 bit0 boost off", spu_en, 8'h00);
    chk_onehot("final");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule